// File: doc/BRIEF.md
# CAN Initialization-Mode and Bus-Idle Synchronizer

This block decides whether a CAN controller core sits in initialization mode or takes part in bus traffic. It holds the software-visible Init and configuration-change-enable bits, accepts a level from the error logic that reports the bus-off state, and watches the sampled receive bit stream, one bit per bit-time strobe. Hardware reset, bus-off and a software write with Init set all place the core in initialization. While in that mode, four outputs take effect. The transmit pin is forced recessive. The error counters are frozen. The bit stream processor is held off the bus. Writes to the bit timing register are let through only when the change-enable bit is also set.

When software clears Init, the block does not release the core at once. It counts recessive samples taken on the bit-time strobe and restarts the count on any dominant sample. Only when a run of eleven recessive bits has been seen does the block raise the active flag. Setting Init again during this wait abandons it. Clock cycles without a strobe never advance the count.

Top module: `can_init_ctrl`

## Requirements
- R1: After hardware reset (rst_n low), init_o reads 1, cce_o reads 0, core_active is 0, tx_force_rec is 1 and err_freeze is 1.
- R2: A cycle with bus_off high makes init_o read 1 from the next cycle on. This holds even if the same cycle carries a software write with init_d = 0. cce_o keeps its value.
- R3: A cycle with ctl_we high loads init_d into init_o and cce_d into cce_o, visible from the next cycle.
- R4: While init_o is 1, core_active is 0 and tx_force_rec is 1. Whenever core_active is 0, tx_force_rec is 1.
- R5: err_freeze equals init_o in every cycle.
- R6: btr_we is 1 exactly when btr_wr_req, init_o and cce_o are all 1. It is combinational and takes effect in the same cycle.
- R7: Counting starts with the first strobe sampled in a cycle where init_o reads 0. Each cycle with bit_strobe high and rx_bit = 1 (recessive) counts one bit. core_active rises in the cycle after the clock edge that samples the 11th consecutive recessive bit, and not before.
- R8: A cycle with bit_strobe high and rx_bit = 0 (dominant) during the wait restarts the run. Eleven further consecutive recessive bits are then needed.
- R9: Clock cycles with bit_strobe low do not advance the run, whatever rx_bit is.
- R10: Setting Init during the wait clears the run. After Init is cleared again, a full eleven recessive bits are needed.
- R11: Setting Init while core_active is 1 drops core_active in the first cycle in which init_o reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low; enters initialization |
| ctl_we | input | 1 | Software write strobe for the control bits |
| init_d | input | 1 | Init value written by software |
| cce_d | input | 1 | Configuration-change-enable value written by software |
| bus_off | input | 1 | Bus-off indication from the error logic |
| rx_bit | input | 1 | Sampled receive bit, 1 = recessive |
| bit_strobe | input | 1 | One-cycle pulse marking a bit-time sample |
| btr_wr_req | input | 1 | Software request to write the bit timing register |
| init_o | output | 1 | Current Init bit as software reads it |
| cce_o | output | 1 | Current configuration-change-enable bit |
| core_active | output | 1 | Bit stream processor may take part in bus traffic |
| tx_force_rec | output | 1 | Force the transmit pin recessive |
| err_freeze | output | 1 | Hold the error counters unchanged |
| btr_we | output | 1 | Write enable for the bit timing register |

## Verification
The idle wait is fed a table of bit patterns, each following a fresh clear of Init. A clean run of exactly eleven recessive bits and a run of ten separate the release point by one bit. Runs broken by a single dominant bit, with ten or eleven recessive bits after the break, show that the count restarts rather than resumes. Leading dominant bits and alternating bits confirm that only consecutive recessive bits count. Further tests hold rx_bit recessive without strobes, interrupt a partial wait with Init, and raise bus-off against a software clear. These separate strobe-gated counting from per-clock counting, and hardware set from software write priority.

// File: rtl/can_init_pkg.sv
package can_init_pkg;

  // Synchronizer phase: held in init, hunting for bus idle, or joined.
  typedef enum logic [1:0] {
    PH_INIT = 2'd0,
    PH_SYNC = 2'd1,
    PH_LIVE = 2'd2
  } sync_phase_e;

endpackage

// File: rtl/can_ctl_reg.sv
module can_ctl_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_we,
  input  logic init_d,
  input  logic cce_d,
  input  logic bus_off,
  output logic init_q,
  output logic cce_q,
  output logic init_set_evt
);

  // Any source that drives Init to one in the coming edge.
  assign init_set_evt = bus_off | (ctl_we & init_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= 1'b1;
      cce_q  <= 1'b0;
    end else begin
      if (ctl_we) begin
        init_q <= init_d;
        cce_q  <= cce_d;
      end
      // Hardware set wins over a software clear in the same cycle;
      // the change-enable bit is left alone.
      if (bus_off) init_q <= 1'b1;
    end
  end

endmodule

// File: rtl/can_bus_idle_det.sv
module can_bus_idle_det
  import can_init_pkg::*;
#(
  parameter int IDLE_BITS = 11,
  parameter int CNT_W     = $clog2(IDLE_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_init,
  input  logic             bit_strobe,
  input  logic             rx_bit,
  output sync_phase_e      phase,
  output logic [CNT_W-1:0] run_len,
  output logic             idle_seen
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_BITS - 1);

  // Length of the recessive run after one more sample.
  function automatic logic [CNT_W-1:0] run_next(input logic [CNT_W-1:0] cur,
                                                input logic rec);
    return rec ? cur + 1'b1 : '0;
  endfunction

  logic hunting;
  assign hunting   = !hold_init && (phase != PH_LIVE);
  assign idle_seen = hunting && bit_strobe && rx_bit && (run_len == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_INIT;
      run_len <= '0;
    end else if (hold_init) begin
      phase   <= PH_INIT;
      run_len <= '0;
    end else if (phase != PH_LIVE) begin
      if (bit_strobe) begin
        run_len <= run_next(run_len, rx_bit);
      end
      phase <= idle_seen ? PH_LIVE : PH_SYNC;
    end
  end

endmodule

// File: rtl/can_init_gate.sv
module can_init_gate
  import can_init_pkg::*;
(
  input  logic        init_q,
  input  logic        cce_q,
  input  sync_phase_e phase,
  input  logic        btr_wr_req,
  output logic        core_active,
  output logic        tx_force_rec,
  output logic        err_freeze,
  output logic        btr_we
);

  // Init takes effect in the same cycle it reads one, ahead of the phase.
  assign core_active  = (phase == PH_LIVE) && !init_q;
  assign tx_force_rec = !core_active;
  assign err_freeze   = init_q;
  assign btr_we       = btr_wr_req && init_q && cce_q;

endmodule

// File: rtl/can_init_ctrl.sv
module can_init_ctrl
  import can_init_pkg::*;
#(
  parameter int IDLE_BITS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_we,
  input  logic init_d,
  input  logic cce_d,
  input  logic bus_off,
  input  logic rx_bit,
  input  logic bit_strobe,
  input  logic btr_wr_req,
  output logic init_o,
  output logic cce_o,
  output logic core_active,
  output logic tx_force_rec,
  output logic err_freeze,
  output logic btr_we
);

  localparam int CNT_W = $clog2(IDLE_BITS + 1);

  logic             init_q;
  logic             cce_q;
  logic             init_set_evt;
  sync_phase_e      phase;
  logic [CNT_W-1:0] idle_cnt;
  logic             idle_seen;

  can_ctl_reg u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl_we       (ctl_we),
    .init_d       (init_d),
    .cce_d        (cce_d),
    .bus_off      (bus_off),
    .init_q       (init_q),
    .cce_q        (cce_q),
    .init_set_evt (init_set_evt)
  );

  can_bus_idle_det #(
    .IDLE_BITS (IDLE_BITS),
    .CNT_W     (CNT_W)
  ) u_idle (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold_init  (init_q),
    .bit_strobe (bit_strobe),
    .rx_bit     (rx_bit),
    .phase      (phase),
    .run_len    (idle_cnt),
    .idle_seen  (idle_seen)
  );

  can_init_gate u_gate (
    .init_q       (init_q),
    .cce_q        (cce_q),
    .phase        (phase),
    .btr_wr_req   (btr_wr_req),
    .core_active  (core_active),
    .tx_force_rec (tx_force_rec),
    .err_freeze   (err_freeze),
    .btr_we       (btr_we)
  );

  assign init_o = init_q;
  assign cce_o  = cce_q;

endmodule

// File: rtl/can_init_ctrl_chk.sv
module can_init_ctrl_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_off,
  input logic             ctl_we,
  input logic             rx_bit,
  input logic             bit_strobe,
  input logic             btr_wr_req,
  input logic             init_o,
  input logic             cce_o,
  input logic             core_active,
  input logic             tx_force_rec,
  input logic             err_freeze,
  input logic             btr_we,
  input logic             init_set_evt,
  input logic             idle_seen,
  input logic [CNT_W-1:0] idle_cnt
);

  p_busoff_sets_init_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_off |=> init_o);

  p_cce_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> $stable(cce_o));

  p_set_init_r3: assert property (@(posedge clk) disable iff (!rst_n)
    init_set_evt |=> init_o);

  p_init_blocks_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
    init_o |-> (!core_active && tx_force_rec));

  p_freeze_follows_init_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_freeze == init_o);

  p_btr_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    btr_we |-> (btr_wr_req && init_o && cce_o));

  p_join_after_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_active) |-> $past(idle_seen && bit_strobe && rx_bit));

  p_dominant_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_strobe && !rx_bit && !core_active) |=> (idle_cnt == '0));

  p_no_strobe_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_strobe && !init_o) |=> $stable(idle_cnt));

  p_init_clears_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
    init_o |=> (idle_cnt == '0));

endmodule

bind can_init_ctrl can_init_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_off      (bus_off),
  .ctl_we       (ctl_we),
  .rx_bit       (rx_bit),
  .bit_strobe   (bit_strobe),
  .btr_wr_req   (btr_wr_req),
  .init_o       (init_o),
  .cce_o        (cce_o),
  .core_active  (core_active),
  .tx_force_rec (tx_force_rec),
  .err_freeze   (err_freeze),
  .btr_we       (btr_we),
  .init_set_evt (init_set_evt),
  .idle_seen    (idle_seen),
  .idle_cnt     (idle_cnt)
);

// File: tb/can_init_ctrl_test.sv
`timescale 1ns/1ps
module can_init_ctrl_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 1'b0, init_d = 1'b0, cce_d = 1'b0, bus_off = 1'b0;
  logic rx_bit = 1'b1, bit_strobe = 1'b0, btr_wr_req = 1'b0;
  logic init_o, cce_o, core_active, tx_force_rec, err_freeze, btr_we;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  can_init_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .init_d(init_d), .cce_d(cce_d),
    .bus_off(bus_off), .rx_bit(rx_bit), .bit_strobe(bit_strobe),
    .btr_wr_req(btr_wr_req), .init_o(init_o), .cce_o(cce_o),
    .core_active(core_active), .tx_force_rec(tx_force_rec),
    .err_freeze(err_freeze), .btr_we(btr_we)
  );

  // Idle-wait patterns, fed LSB first after a fresh clear of Init.
  localparam int NV = 8;
  localparam logic [31:0] VBITS [NV] = '{32'h0000_07FF, 32'h0000_03FF,
    32'h0000_0FFE, 32'h001F_FBFF, 32'h003F_FBFF, 32'h5555_5555,
    32'h0000_FFE0, 32'h0000_0FFF};
  localparam int VLEN [NV] = '{11, 10, 12, 21, 22, 32, 16, 12};
  localparam bit VEXP [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic ctl_write(input logic i, input logic c);
    @(negedge clk);
    ctl_we = 1'b1; init_d = i; cce_d = c;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    rx_bit = b; bit_strobe = 1'b1;
    @(negedge clk);
    bit_strobe = 1'b0; rx_bit = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_run(input int n);
    for (int k = 0; k < n; k++) send_bit(1'b1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 init_o", init_o, 1'b1);
    chk("R1 cce_o", cce_o, 1'b0);
    chk("R1 core_active", core_active, 1'b0);
    chk("R1 tx_force_rec", tx_force_rec, 1'b1);
    chk("R1 err_freeze", err_freeze, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);

    // R6: bit timing write gating, all four Init/CCE combinations
    for (int m = 0; m < 4; m++) begin
      ctl_write(m[0], m[1]);
      btr_wr_req = 1'b1;
      #1;
      chk("R6 btr_we req", btr_we, m[0] & m[1]);
      btr_wr_req = 1'b0;
      #1;
      chk("R6 btr_we idle", btr_we, 1'b0);
      chk("R3 init_o", init_o, m[0]);
      chk("R3 cce_o", cce_o, m[1]);
      chk("R5 err_freeze", err_freeze, m[0]);
      if (m[0]) chk("R4 tx_force_rec", tx_force_rec, 1'b1);
    end

    // R7 / R8: table of idle-wait patterns
    for (int v = 0; v < NV; v++) begin
      ctl_write(1'b1, 1'b0);
      chk("R4 inactive in init", core_active, 1'b0);
      ctl_write(1'b0, 1'b0);
      for (int k = 0; k < VLEN[v]; k++) send_bit(VBITS[v][k]);
      chk("R7/R8 pattern active", core_active, VEXP[v]);
      chk("R4 tx follows active", tx_force_rec, !VEXP[v]);
    end

    // R7: release exactly at the 11th bit, not the 10th
    ctl_write(1'b1, 1'b0);
    ctl_write(1'b0, 1'b0);
    send_run(10);
    chk("R7 after 10", core_active, 1'b0);
    @(negedge clk);
    rx_bit = 1'b1; bit_strobe = 1'b1;
    #1;
    chk("R7 before edge of 11th", core_active, 1'b0);
    @(negedge clk);
    bit_strobe = 1'b0;
    chk("R7 after 11th edge", core_active, 1'b1);

    // R11: set Init while active
    @(negedge clk);
    ctl_we = 1'b1; init_d = 1'b1; cce_d = 1'b0;
    @(negedge clk);
    ctl_we = 1'b0;
    chk("R11 init_o", init_o, 1'b1);
    chk("R11 core_active dropped", core_active, 1'b0);

    // R9: recessive for many cycles without strobes
    ctl_write(1'b0, 1'b0);
    rx_bit = 1'b1;
    repeat (60) @(negedge clk);
    chk("R9 no strobe no join", core_active, 1'b0);
    send_run(10);
    chk("R9 ten strobes", core_active, 1'b0);
    send_run(1);
    chk("R9 eleventh strobe", core_active, 1'b1);

    // R10: interrupted wait restarts
    ctl_write(1'b1, 1'b0);
    ctl_write(1'b0, 1'b0);
    send_run(8);
    ctl_write(1'b1, 1'b0);
    ctl_write(1'b0, 1'b0);
    send_run(8);
    chk("R10 8+8 not joined", core_active, 1'b0);
    send_run(3);
    chk("R10 full run joined", core_active, 1'b1);

    // R2: bus-off beats a same-cycle software clear, CCE kept
    ctl_write(1'b0, 1'b1);
    @(negedge clk);
    bus_off = 1'b1; ctl_we = 1'b1; init_d = 1'b0; cce_d = 1'b1;
    @(negedge clk);
    bus_off = 1'b0; ctl_we = 1'b0;
    chk("R2 init_o set", init_o, 1'b1);
    chk("R2 cce_o kept", cce_o, 1'b1);
    chk("R2 core_active", core_active, 1'b0);
    chk("R2 err_freeze", err_freeze, 1'b1);
    @(negedge clk);
    bus_off = 1'b1;
    @(negedge clk);
    bus_off = 1'b0;
    chk("R2 init_o alone", init_o, 1'b1);
    chk("R2 cce_o alone", cce_o, 1'b1);

    finish_run();
  end

endmodule